// File: doc/BRIEF.md
# Serial Logic-Analyzer Command Decoder

This block sits behind a UART receiver and turns the incoming byte stream into the configuration of a serial-controlled logic analyzer. Each byte with its top bit clear is a complete one-byte command. A byte with its top bit set opens a five-byte command: that opcode byte is followed by four argument bytes, and the first argument byte carries bits 31:24. The decoder drives the register outputs directly: per-stage trigger mask, value and configuration words, the sample-rate divider, the capture size and the flag word. It also pulses one-cycle strobes for the run, identify and metadata requests. The sampling clock is clock / (divider + 1), and this rate is doubled when demultiplexing is enabled. Other logic in the analyzer computes the rate from the divider and flag outputs.

Framing is kept by a state machine with five states. FR_IDLE waits for an opcode. FR_ARG0, FR_ARG1, FR_ARG2 and FR_ARG3 collect the four argument bytes. The transitions are:
- FR_IDLE to FR_ARG0 on an opcode with its top bit set.
- FR_ARGn to the next argument state on each accepted byte.
- FR_ARG3 to FR_IDLE on the last argument byte.

A host that has lost track of the framing sends five 0x00 bytes. Any partial command is completed by zero bytes, so the last 0x00 is always decoded as a reset opcode.

An identify request queues the four-byte reply 0x31 0x53 0x4C 0x4F on a valid/ready transmit interface. The reply has its own two-state machine. TX_IDLE goes to TX_SEND on an identify request. TX_SEND goes back to TX_IDLE once the fourth byte has been accepted.

Top module: `lacmd_decoder`

## Requirements
- R1: A received byte with bit 7 = 0 is a short command and is decoded alone. A byte with bit 7 = 1 starts a long command that absorbs the next four accepted bytes as a 32-bit argument, first byte = bits 31:24. Argument bytes never act as opcodes, and the decoder does not advance while rx_valid is low.
- R2: Short opcode 0x00 clears every configuration register to zero and sets the divider to DIV_RST. After five consecutive 0x00 bytes from any framing position, the decoder is in FR_IDLE with exactly this reset configuration.
- R3: Short opcode 0x02 queues the reply bytes 0x31, 0x53, 0x4C, 0x4F in that order. One byte is sent per cycle with tx_valid and tx_ready both high. tx_valid and tx_data hold steady while tx_ready is low. An identify that arrives during a reply adds no bytes.
- R4: Short opcodes 0x01, 0x02 and 0x04 raise run_pulse, id_pulse and meta_pulse respectively. The strobe is high for exactly the one cycle after the edge that accepts the opcode. Other short opcodes besides 0x00 have no effect.
- R5: A long opcode 0xC0 | (stage << 2) | sel writes the argument to a trigger register of that stage: sel 0 selects the mask, 1 the value and 2 the configuration. trig_start_stage[stage] equals bit 3 of that stage's configuration.
- R6: Long opcode 0x80 loads the divider with argument bits 23:0.
- R7: Long opcode 0x81 loads the capture size. read_count_m1 = {arg[23:16], arg[31:24]} and delay_count_m1 = {arg[7:0], arg[15:8]}, so the bytes are swapped within each half.
- R8: Long opcode 0x82 loads the flag word. group_disable = bits 5:2 (a 1 disables that 8-bit channel group), demux_en = bit 0, filter_en = bit 1 and rle_en = bit 8.
- R9: A long opcode other than those above (for example 0xA0 to 0xBF, or sel 3) still consumes four argument bytes. It changes no register and raises no strobe.
- R10: Hardware reset gives FR_IDLE, TX_IDLE, tx_valid low, all strobes low, all registers zero and the divider at DIV_RST. A register write becomes visible one clock after the edge that accepts its last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | rx_data holds a new byte this cycle |
| tx_data | output | 8 | Reply byte |
| tx_valid | output | 1 | Reply byte available |
| tx_ready | input | 1 | Transmitter accepts tx_data |
| run_pulse | output | 1 | Run request strobe |
| id_pulse | output | 1 | Identify request strobe |
| meta_pulse | output | 1 | Metadata request strobe |
| trig_mask | output | STAGES×32 | Trigger mask per stage |
| trig_value | output | STAGES×32 | Trigger value per stage |
| trig_cfg | output | STAGES×32 | Trigger configuration per stage |
| trig_start_stage | output | STAGES | Stage marked to start capture |
| divider | output | DIV_W | Sample-rate divider |
| read_count_m1 | output | 16 | Read count minus one |
| delay_count_m1 | output | 16 | Delay count minus one |
| flags | output | 32 | Raw flag word |
| group_disable | output | 4 | Channel-group disable bits |
| demux_en | output | 1 | Demultiplexed sampling enable |
| filter_en | output | 1 | Input filter enable |
| rle_en | output | 1 | Run-length encoding enable |

## Verification
A framing counter that is off by even one byte shows up at the ports on the next long command. Every later argument lands in the wrong register or with shifted bytes, and an argument byte such as 0x01 leaks out as a run strobe. This is visible within five accepted bytes of the fault. A byte-order mistake in the capture-size or divider path shows up one cycle after the write, as a halfword with swapped bytes. A wrong reply index shows in the first reply byte or in a reply longer than four bytes.

// File: rtl/lacmd_pkg.sv
`timescale 1ns/100ps
package lacmd_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        FR_IDLE, FR_ARG0, FR_ARG1, FR_ARG2, FR_ARG3
    } frame_state_t;

    typedef enum logic {
        TX_IDLE, TX_SEND
    } reply_state_t;

    localparam logic [7:0] OP_RESET = 8'h00;
    localparam logic [7:0] OP_RUN   = 8'h01;
    localparam logic [7:0] OP_IDENT = 8'h02;
    localparam logic [7:0] OP_META  = 8'h04;
    localparam logic [7:0] OP_DIV   = 8'h80;
    localparam logic [7:0] OP_SIZE  = 8'h81;
    localparam logic [7:0] OP_FLAGS = 8'h82;
    localparam logic [3:0] OP_TRIG_HI = 4'hC;

    localparam int FLG_DEMUX  = 0;
    localparam int FLG_FILTER = 1;
    localparam int FLG_GRP_LO = 2;
    localparam int FLG_RLE    = 8;

    function automatic logic [7:0] reply_byte(input logic [1:0] idx);
        case (idx)
            2'd0:    return 8'h31;
            2'd1:    return 8'h53;
            2'd2:    return 8'h4C;
            default: return 8'h4F;
        endcase
    endfunction
endpackage

// File: rtl/lacmd_framer.sv
`timescale 1ns/100ps
module lacmd_framer
    import lacmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BYTE_W-1:0]   rx_data,
    input  logic                rx_valid,
    output logic                short_vld,
    output logic                long_vld,
    output logic [BYTE_W-1:0]   op,
    output logic [WORD_W-1:0]   arg
);
    frame_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_IDLE: if (rx_valid && rx_data[BYTE_W-1]) state_d = FR_ARG0;
            FR_ARG0: if (rx_valid) state_d = FR_ARG1;
            FR_ARG1: if (rx_valid) state_d = FR_ARG2;
            FR_ARG2: if (rx_valid) state_d = FR_ARG3;
            FR_ARG3: if (rx_valid) state_d = FR_IDLE;
            default: state_d = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            short_vld <= 1'b0;
            long_vld  <= 1'b0;
            op        <= '0;
            arg       <= '0;
        end else begin
            short_vld <= 1'b0;
            long_vld  <= 1'b0;
            if (rx_valid) begin
                if (state_q == FR_IDLE) begin
                    op        <= rx_data;
                    short_vld <= ~rx_data[BYTE_W-1];
                end else begin
                    arg      <= {arg[WORD_W-BYTE_W-1:0], rx_data};
                    long_vld <= (state_q == FR_ARG3);
                end
            end
        end
    end

    // R1
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(state_q) && $stable(arg));

    // R1
    long_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        long_vld |=> !long_vld);
endmodule

// File: rtl/lacmd_regs.sv
`timescale 1ns/100ps
module lacmd_regs
    import lacmd_pkg::*;
#(
    parameter int          STAGES  = 4,
    parameter int          DIV_W   = 24,
    parameter int unsigned DIV_RST = 99
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           short_vld,
    input  logic                           long_vld,
    input  logic [BYTE_W-1:0]              op,
    input  logic [WORD_W-1:0]              arg,
    output logic [STAGES-1:0][WORD_W-1:0]  trig_mask,
    output logic [STAGES-1:0][WORD_W-1:0]  trig_value,
    output logic [STAGES-1:0][WORD_W-1:0]  trig_cfg,
    output logic [STAGES-1:0]              trig_start_stage,
    output logic [DIV_W-1:0]               divider,
    output logic [15:0]                    read_count_m1,
    output logic [15:0]                    delay_count_m1,
    output logic [WORD_W-1:0]              flags
);
    localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RST);
    localparam int START_BIT = 3;

    logic clr;
    assign clr = short_vld && (op == OP_RESET);

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WORD_W-1:0] m_q, v_q, c_q;
        logic hit;
        assign hit = long_vld && (op[7:4] == OP_TRIG_HI) && (op[3:2] == 2'(s));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                m_q <= '0; v_q <= '0; c_q <= '0;
            end else if (clr) begin
                m_q <= '0; v_q <= '0; c_q <= '0;
            end else if (hit) begin
                case (op[1:0])
                    2'd0:    m_q <= arg;
                    2'd1:    v_q <= arg;
                    2'd2:    c_q <= arg;
                    default: ;
                endcase
            end
        end

        assign trig_mask[s]        = m_q;
        assign trig_value[s]       = v_q;
        assign trig_cfg[s]         = c_q;
        assign trig_start_stage[s] = c_q[START_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            divider        <= DIV_INIT;
            read_count_m1  <= '0;
            delay_count_m1 <= '0;
            flags          <= '0;
        end else if (clr) begin
            divider        <= DIV_INIT;
            read_count_m1  <= '0;
            delay_count_m1 <= '0;
            flags          <= '0;
        end else if (long_vld) begin
            if (op == OP_DIV) divider <= arg[DIV_W-1:0];
            if (op == OP_SIZE) begin
                read_count_m1  <= {arg[23:16], arg[31:24]};
                delay_count_m1 <= {arg[7:0],   arg[15:8]};
            end
            if (op == OP_FLAGS) flags <= arg;
        end
    end

    // R2
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (short_vld && op == OP_RESET) |=> (divider == DIV_INIT && flags == '0
            && read_count_m1 == '0 && trig_cfg == '0));

    // R9
    unknown_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (long_vld && op[7:5] == 3'b101) |=> ($stable(divider) && $stable(flags)
            && $stable(read_count_m1) && $stable(trig_mask)));
endmodule

// File: rtl/lacmd_id_tx.sv
`timescale 1ns/100ps
module lacmd_id_tx
    import lacmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data
);
    reply_state_t state_q, state_d;
    logic [1:0]   idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (start) state_d = TX_SEND;
            TX_SEND: if (tx_ready && idx_q == 2'd3) state_d = TX_IDLE;
            default: state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  idx_q <= '0;
        else if (state_q == TX_IDLE) idx_q <= '0;
        else if (tx_ready)           idx_q <= idx_q + 2'd1;
    end

    always_comb begin
        tx_valid = (state_q == TX_SEND);
        tx_data  = reply_byte(idx_q);
    end

    // R3
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R3
    reply_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> tx_data == 8'h31);

    // R3
    reply_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_data == 8'h4F) |=> !tx_valid);
endmodule

// File: rtl/lacmd_decoder.sv
`timescale 1ns/100ps
module lacmd_decoder
    import lacmd_pkg::*;
#(
    parameter int          STAGES  = 4,
    parameter int          DIV_W   = 24,
    parameter int unsigned DIV_RST = 99
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [7:0]                rx_data,
    input  logic                      rx_valid,
    output logic [7:0]                tx_data,
    output logic                      tx_valid,
    input  logic                      tx_ready,
    output logic                      run_pulse,
    output logic                      id_pulse,
    output logic                      meta_pulse,
    output logic [STAGES-1:0][31:0]   trig_mask,
    output logic [STAGES-1:0][31:0]   trig_value,
    output logic [STAGES-1:0][31:0]   trig_cfg,
    output logic [STAGES-1:0]         trig_start_stage,
    output logic [DIV_W-1:0]          divider,
    output logic [15:0]               read_count_m1,
    output logic [15:0]               delay_count_m1,
    output logic [31:0]               flags,
    output logic [3:0]                group_disable,
    output logic                      demux_en,
    output logic                      filter_en,
    output logic                      rle_en
);
    logic              short_vld, long_vld;
    logic [BYTE_W-1:0] op;
    logic [WORD_W-1:0] arg;

    lacmd_framer u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .short_vld (short_vld),
        .long_vld  (long_vld),
        .op        (op),
        .arg       (arg)
    );

    lacmd_regs #(.STAGES(STAGES), .DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
        .clk              (clk),
        .rst_n            (rst_n),
        .short_vld        (short_vld),
        .long_vld         (long_vld),
        .op               (op),
        .arg              (arg),
        .trig_mask        (trig_mask),
        .trig_value       (trig_value),
        .trig_cfg         (trig_cfg),
        .trig_start_stage (trig_start_stage),
        .divider          (divider),
        .read_count_m1    (read_count_m1),
        .delay_count_m1   (delay_count_m1),
        .flags            (flags)
    );

    assign run_pulse  = short_vld && (op == OP_RUN);
    assign id_pulse   = short_vld && (op == OP_IDENT);
    assign meta_pulse = short_vld && (op == OP_META);

    lacmd_id_tx u_id_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (id_pulse),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data)
    );

    assign group_disable = flags[FLG_GRP_LO +: 4];
    assign demux_en      = flags[FLG_DEMUX];
    assign filter_en     = flags[FLG_FILTER];
    assign rle_en        = flags[FLG_RLE];

    // R4
    strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_pulse || id_pulse || meta_pulse) |-> $past(rx_valid));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({run_pulse, id_pulse, meta_pulse}));
endmodule

// File: tb/lacmd_decoder_test.sv
`timescale 1ns/100ps
module lacmd_decoder_test;
    localparam int          STAGES  = 4;
    localparam int          DIV_W   = 24;
    localparam int unsigned DIV_RST = 99;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] rx_data = '0;
    logic rx_valid = 1'b0, tx_ready = 1'b0;
    logic [7:0] tx_data;
    logic tx_valid, run_pulse, id_pulse, meta_pulse;
    logic [STAGES-1:0][31:0] trig_mask, trig_value, trig_cfg;
    logic [STAGES-1:0] trig_start_stage;
    logic [DIV_W-1:0] divider;
    logic [15:0] read_count_m1, delay_count_m1;
    logic [31:0] flags;
    logic [3:0] group_disable;
    logic demux_en, filter_en, rle_en;

    always #2.5 clk = ~clk;

    lacmd_decoder #(.STAGES(STAGES), .DIV_W(DIV_W), .DIV_RST(DIV_RST)) uut (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .run_pulse(run_pulse), .id_pulse(id_pulse), .meta_pulse(meta_pulse),
        .trig_mask(trig_mask), .trig_value(trig_value), .trig_cfg(trig_cfg),
        .trig_start_stage(trig_start_stage), .divider(divider),
        .read_count_m1(read_count_m1), .delay_count_m1(delay_count_m1),
        .flags(flags), .group_disable(group_disable), .demux_en(demux_en),
        .filter_en(filter_en), .rle_en(rle_en));

    int n_chk = 0, n_fail = 0;
    logic [31:0] em [STAGES], ev [STAGES], ec [STAGES];
    logic [31:0] ediv, esize, eflags;
    logic s_run, s_id, s_meta, s_any;

    task automatic chk(input logic ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [31:0] w);
        return {w[23:16], w[31:24]};
    endfunction
    function automatic logic [15:0] exp_delay(input logic [31:0] w);
        return {w[7:0], w[15:8]};
    endfunction

    task automatic model_reset();
        for (int s = 0; s < STAGES; s++) begin em[s] = 0; ev[s] = 0; ec[s] = 0; end
        ediv = DIV_RST; esize = 0; eflags = 0;
    endtask

    task automatic model_long(input logic [7:0] op, input logic [31:0] w);
        if (op == 8'h80) ediv = {8'h00, w[23:0]};
        else if (op == 8'h81) esize = w;
        else if (op == 8'h82) eflags = w;
        else if (op[7:4] == 4'hC) begin
            case (op[1:0])
                2'd0: em[op[3:2]] = w;
                2'd1: ev[op[3:2]] = w;
                2'd2: ec[op[3:2]] = w;
                default: ;
            endcase
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); rx_data = b; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
        s_run = run_pulse; s_id = id_pulse; s_meta = meta_pulse;
    endtask

    task automatic send_long(input logic [7:0] op, input logic [31:0] w);
        send_byte(op);
        s_any = s_run | s_id | s_meta;
        for (int i = 3; i >= 0; i--) begin
            send_byte(w[i*8 +: 8]);
            s_any = s_any | s_run | s_id | s_meta;
        end
        @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        for (int s = 0; s < STAGES; s++) begin
            chk(trig_mask[s] == em[s], {tag, " R5 mask"}, trig_mask[s], em[s]);
            chk(trig_value[s] == ev[s], {tag, " R5 value"}, trig_value[s], ev[s]);
            chk(trig_cfg[s] == ec[s], {tag, " R5 cfg"}, trig_cfg[s], ec[s]);
            chk(trig_start_stage[s] == ec[s][3], {tag, " R5 start stage"}, trig_start_stage[s], ec[s][3]);
        end
        chk(divider == ediv[23:0], {tag, " R6 divider"}, divider, ediv[23:0]);
        chk(read_count_m1 == exp_read(esize), {tag, " R7 read"}, read_count_m1, exp_read(esize));
        chk(delay_count_m1 == exp_delay(esize), {tag, " R7 delay"}, delay_count_m1, exp_delay(esize));
        chk(flags == eflags, {tag, " R8 flags"}, flags, eflags);
        chk(group_disable == eflags[5:2], {tag, " R8 groups"}, group_disable, eflags[5:2]);
        chk({rle_en, filter_en, demux_en} == {eflags[8], eflags[1], eflags[0]},
            {tag, " R8 enables"}, {rle_en, filter_en, demux_en}, {eflags[8], eflags[1], eflags[0]});
    endtask

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog R10 actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        string idstr;
        logic [7:0] got [8];
        int nb;
        void'($urandom(32'd20240611));
        idstr = "1SLO";
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check_all("R10");
        chk(!tx_valid && !run_pulse && !id_pulse && !meta_pulse, "R10 outputs idle",
            {tx_valid, run_pulse, id_pulse, meta_pulse}, 0);

        // Directed field checks
        send_long(8'h80, 32'h12345678); model_long(8'h80, 32'h12345678);
        check_all("R6 directed");
        send_long(8'h81, 32'hAABBCCDD); model_long(8'h81, 32'hAABBCCDD);
        chk(read_count_m1 == 16'hBBAA, "R7 read directed", read_count_m1, 16'hBBAA);
        chk(delay_count_m1 == 16'hDDCC, "R7 delay directed", delay_count_m1, 16'hDDCC);
        send_long(8'h82, 32'h0000013D); model_long(8'h82, 32'h0000013D);
        chk(group_disable == 4'hF && demux_en && !filter_en && rle_en, "R8 directed",
            {group_disable, rle_en, filter_en, demux_en}, {4'hF, 3'b101});
        send_long(8'hCA, 32'h00000008); model_long(8'hCA, 32'h00000008);
        chk(trig_start_stage == 4'b0100, "R5 start stage directed", trig_start_stage, 4'b0100);

        // R9: unknown long whose argument bytes look like opcodes
        send_long(8'hA5, 32'h01040201);
        chk(!s_any, "R9 no strobe from argument", s_any, 0);
        check_all("R9 unknown");

        // Random mix
        for (int it = 0; it < 250; it++) begin
            int kind;
            logic [7:0] op;
            logic [31:0] w;
            kind = $urandom % 10;
            w = $urandom;
            if (kind < 6) begin
                case ($urandom % 5)
                    0: op = 8'h80;
                    1: op = 8'h81;
                    2: op = 8'h82;
                    3: op = 8'hA0 | 8'($urandom % 32);
                    default: op = 8'hC0 | 8'($urandom % 16);
                endcase
                if ($urandom % 3 == 0) w[31:24] = 8'h01;
                send_long(op, w); model_long(op, w);
                chk(!s_any, "R1 long command raises no strobe", s_any, 0);
            end else begin
                case ($urandom % 6)
                    0: op = 8'h01;
                    1: op = 8'h04;
                    2: op = 8'h03;
                    3: op = 8'h7F;
                    4: op = 8'h10;
                    default: op = ($urandom % 4 == 0) ? 8'h00 : 8'h01;
                endcase
                send_byte(op);
                chk({s_run, s_id, s_meta} == {op == 8'h01, 1'b0, op == 8'h04}, "R4 strobes",
                    {s_run, s_id, s_meta}, {op == 8'h01, 1'b0, op == 8'h04});
                @(negedge clk);
                chk(!run_pulse && !meta_pulse, "R4 strobe one cycle", {run_pulse, meta_pulse}, 0);
                if (op == 8'h00) model_reset();
            end
            check_all("random");
        end

        // R2: resynchronise from every framing position
        for (int pos = 0; pos < 5; pos++) begin
            send_long(8'h81, 32'h11223344); model_long(8'h81, 32'h11223344);
            if (pos > 0) begin
                send_byte(8'h80);
                for (int k = 1; k < pos; k++) send_byte(8'h5A);
            end
            for (int k = 0; k < 5; k++) send_byte(8'h00);
            @(negedge clk);
            model_reset();
            check_all("R2 resync");
            send_long(8'h80, 32'h00ABCDEF); model_long(8'h80, 32'h00ABCDEF);
            chk(divider == 24'hABCDEF, "R2 framing after resync", divider, 24'hABCDEF);
        end

        // R3: identify reply with random backpressure and a second request
        send_byte(8'h02);
        chk(s_id && !s_run && !s_meta, "R4 identify strobe", {s_run, s_id, s_meta}, 3'b010);
        nb = 0;
        for (int c = 0; c < 80; c++) begin
            logic r;
            @(negedge clk);
            if (c == 0) begin rx_data = 8'h02; rx_valid = 1'b1; end
            else rx_valid = 1'b0;
            r = ($urandom % 2 == 0);
            tx_ready = r;
            if (tx_valid && r) begin
                if (nb < 8) got[nb] = tx_data;
                nb++;
            end
        end
        tx_ready = 1'b0;
        chk(nb == 4, "R3 reply length", nb, 4);
        for (int i = 0; i < 4; i++)
            chk(got[i] == idstr[i], "R3 reply byte", got[i], idstr[i]);
        chk(!tx_valid, "R3 reply finished", tx_valid, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule